// File: doc/BRIEF.md
# Token-Ring Shared Block Directory

This block sits on every node of a token ring that shares one address space. The space is cut into 32-byte blocks, and a block is the smallest unit that moves between nodes. There is no global memory. Each block has a home node, given by the block index modulo the node count. The home node always keeps room for the block, and any node may hold a copy. Each node keeps a table with one entry per block. An entry has a present/up-to-date bit and an exclusive bit. The home bit is fixed per node. Each node also keeps the block's data.

The CPU side takes one word request at a time. A request the table can serve locally completes on the next cycle. Any other request raises a stall. The node then waits for the single circulating free token, turns it into a request packet and sends it round the ring. Passing nodes fill the packet, invalidate their own copies, or forward it unchanged. When the packet comes back to the sender, the node updates its table, finishes the CPU access and puts the free token back on the ring. The ring is a valid/ready packet interface with one register stage per node. A node holds at most CAP blocks whose home is another node. When a miss would go past that limit, the node evicts a block first. It picks the block with a pseudo-random scan and sends it back to its home node.

Top module: `ring_block_dir`

## Requirements
- R1: A read of a present block completes locally. cpu_done is high in the cycle after acceptance, with the addressed word on cpu_rdata, and cpu_stall never rises.
- R2: A read of an absent block raises cpu_stall. After the node captures the free token (kind 0), it emits a read request (kind 1) carrying its node id and the block index. cpu_stall falls in the same cycle that cpu_done rises.
- R3: Every read on every node returns the last value written to that word by any node. A node that serves a read request keeps a readable copy, so its next read of that block is a local hit.
- R4: A write to a block held exclusively updates the word locally in one cycle. It sends no packet and does not stall.
- R5: A write to a block held but not exclusive sends an invalidate packet (kind 2). The node then holds the block exclusively. Other nodes drop their copies, so their next read of the block misses.
- R6: A write to an absent block sends a combined read-and-invalidate packet (kind 3). The first holder copies the block into the packet, and all holders drop their copies. The requester merges its word into the returned block.
- R7: Suppose CAP non-home blocks are present and a miss needs a new non-home block. The node first sends a writeback packet (kind 4) with the victim's data, and the victim's home stores it. The same token then carries the request. A later read of the victim on this node misses and returns the correct value.
- R8: A block whose home is this node is never chosen as an eviction victim.
- R9: After reset, a node holds its home blocks (index modulo node count equal to its id) present and exclusive, holds no other block, keeps all data zero, and does not stall.
- R10: A packet that touches no block held by this node leaves the node unchanged on the next ring hop. This covers the free token and requests for blocks the node does not hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until cpu_done or cpu_stall is seen |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: block index above word select |
| cpu_wdata | input | WORD_W | Write data |
| cpu_stall | output | 1 | Request is waiting on the ring |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read data, or the written word for writes |
| rin_valid | input | 1 | Incoming packet valid |
| rin_ready | output | 1 | Incoming packet accepted |
| rin_kind | input | 3 | 0 free, 1 read, 2 invalidate, 3 read-invalidate, 4 writeback |
| rin_src | input | NODE_W | Originating node |
| rin_blk | input | BLK_W | Block index |
| rin_served | input | 1 | Packet already filled by a holder or home |
| rin_data | input | LINE_W | Block data |
| rout_valid | output | 1 | Outgoing packet valid |
| rout_ready | input | 1 | Next node accepts |
| rout_kind | output | 3 | Outgoing kind |
| rout_src | output | NODE_W | Outgoing originator |
| rout_blk | output | BLK_W | Outgoing block index |
| rout_served | output | 1 | Outgoing served flag |
| rout_data | output | LINE_W | Outgoing block data |

## Verification
A wrong present or exclusive bit shows up at the ports quickly. A read that should hit raises cpu_stall instead, or a request packet of the wrong kind leaves the node within a ring round trip. An invalidation that is missed or lost shows up later, as a stale value on another node's cpu_rdata the next time that node reads the word. A bad eviction choice shows up on the first writeback packet, as a home block index or a victim that still hits. Packet kinds at the node's output and read data on all nodes are therefore compared with a shared-memory model after every access.

// File: rtl/ring_block_dir.sv
module ring_block_dir #(
  parameter int NODES       = 3,
  parameter int NODE_ID     = 0,
  parameter int NBLK        = 8,
  parameter int CAP         = 2,
  parameter int BLOCK_BYTES = 32,
  parameter int WORD_W      = 32,
  localparam int WORDS  = BLOCK_BYTES * 8 / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BLK_W  = $clog2(NBLK),
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int ADDR_W = BLK_W + WSEL_W,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              rin_valid,
  output logic              rin_ready,
  input  logic [2:0]        rin_kind,
  input  logic [NODE_W-1:0] rin_src,
  input  logic [BLK_W-1:0]  rin_blk,
  input  logic              rin_served,
  input  logic [LINE_W-1:0] rin_data,
  output logic              rout_valid,
  input  logic              rout_ready,
  output logic [2:0]        rout_kind,
  output logic [NODE_W-1:0] rout_src,
  output logic [BLK_W-1:0]  rout_blk,
  output logic              rout_served,
  output logic [LINE_W-1:0] rout_data
);

  localparam logic [2:0] K_FREE = 3'd0, K_RD = 3'd1, K_INV = 3'd2, K_RDINV = 3'd3, K_WB = 3'd4;
  localparam logic [NODE_W-1:0] ME = NODE_W'(NODE_ID);

  function automatic logic [NBLK-1:0] home_mask();
    logic [NBLK-1:0] m;
    for (int b = 0; b < NBLK; b++) m[b] = ((b % NODES) == NODE_ID);
    return m;
  endfunction
  localparam logic [NBLK-1:0] HOME = home_mask();

  function automatic logic [WORD_W-1:0] get_word(logic [LINE_W-1:0] l, logic [WSEL_W-1:0] w);
    return l[w*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(logic [LINE_W-1:0] l, logic [WSEL_W-1:0] w,
                                                 logic [WORD_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    r[w*WORD_W +: WORD_W] = d;
    return r;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_TOK, S_RET} st_t;

  st_t               st;
  logic [NBLK-1:0]   vld, exc;
  logic [LINE_W-1:0] line [NBLK];
  logic              p_we;
  logic [BLK_W-1:0]  p_blk;
  logic [WSEL_W-1:0] p_word;
  logic [WORD_W-1:0] p_wdata;
  logic [7:0]        lfsr;
  logic [BLK_W-1:0]  victim;

  wire [BLK_W-1:0]  cpu_blk  = cpu_addr[ADDR_W-1:WSEL_W];
  wire [WSEL_W-1:0] cpu_wsel = cpu_addr[WSEL_W-1:0];
  wire in_fire  = rin_valid && rin_ready;
  wire collide  = in_fire && rin_kind != K_FREE && rin_blk == cpu_blk;
  wire accept   = cpu_req && st == S_IDLE && !collide;
  wire cpu_hit  = cpu_we ? exc[cpu_blk] : vld[cpu_blk];
  wire pend_hit = p_we ? exc[p_blk] : vld[p_blk];
  wire [2:0] req_kind = p_we ? (vld[p_blk] ? K_INV : K_RDINV) : K_RD;
  wire need_ev  = (req_kind != K_INV) && !HOME[p_blk] && ($countones(vld & ~HOME) >= CAP);

  assign rin_ready = !rout_valid || rout_ready;
  assign cpu_stall = (st != S_IDLE);

  always_comb begin
    logic found;
    logic [BLK_W-1:0] idx;
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      idx = lfsr[BLK_W-1:0] + BLK_W'(i);
      if (!found && vld[idx] && !HOME[idx]) begin
        victim = idx;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vld <= HOME;
      exc <= HOME;
      for (int b = 0; b < NBLK; b++) line[b] <= '0;
      p_we <= 1'b0; p_blk <= '0; p_word <= '0; p_wdata <= '0;
      lfsr <= 8'hA5;
      cpu_done <= 1'b0; cpu_rdata <= '0;
      rout_valid <= 1'b0; rout_kind <= K_FREE; rout_src <= '0;
      rout_blk <= '0; rout_served <= 1'b0; rout_data <= '0;
    end else begin
      cpu_done <= 1'b0;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (rout_valid && rout_ready) rout_valid <= 1'b0;

      if (accept) begin
        if (cpu_hit) begin
          cpu_done  <= 1'b1;
          cpu_rdata <= cpu_we ? cpu_wdata : get_word(line[cpu_blk], cpu_wsel);
          if (cpu_we) line[cpu_blk] <= put_word(line[cpu_blk], cpu_wsel, cpu_wdata);
        end else begin
          st <= S_TOK;
          p_we <= cpu_we; p_blk <= cpu_blk; p_word <= cpu_wsel; p_wdata <= cpu_wdata;
        end
      end

      if (in_fire) begin
        rout_valid  <= 1'b1;
        rout_kind   <= rin_kind;
        rout_src    <= rin_src;
        rout_blk    <= rin_blk;
        rout_served <= rin_served;
        rout_data   <= rin_data;
        if (rin_kind == K_FREE) begin
          if (st == S_TOK) begin
            if (pend_hit) begin
              st <= S_IDLE;
              cpu_done  <= 1'b1;
              cpu_rdata <= p_we ? p_wdata : get_word(line[p_blk], p_word);
              if (p_we) line[p_blk] <= put_word(line[p_blk], p_word, p_wdata);
            end else if (need_ev) begin
              st <= S_RET;
              rout_kind <= K_WB; rout_src <= ME; rout_blk <= victim;
              rout_served <= 1'b0; rout_data <= line[victim];
              vld[victim] <= 1'b0; exc[victim] <= 1'b0;
            end else begin
              st <= S_RET;
              rout_kind <= req_kind; rout_src <= ME; rout_blk <= p_blk;
              rout_served <= 1'b0; rout_data <= '0;
            end
          end
        end else if (rin_src == ME && st == S_RET) begin
          if (rin_kind == K_WB) begin
            rout_kind <= req_kind; rout_blk <= p_blk; rout_served <= 1'b0; rout_data <= '0;
          end else begin
            st <= S_IDLE;
            cpu_done  <= 1'b1;
            rout_kind <= K_FREE; rout_served <= 1'b0; rout_data <= '0;
            case (rin_kind)
              K_RD: begin
                vld[p_blk] <= 1'b1; exc[p_blk] <= 1'b0;
                line[p_blk] <= rin_data;
                cpu_rdata <= get_word(rin_data, p_word);
              end
              K_INV: begin
                exc[p_blk] <= 1'b1;
                line[p_blk] <= put_word(line[p_blk], p_word, p_wdata);
                cpu_rdata <= p_wdata;
              end
              default: begin
                vld[p_blk] <= 1'b1; exc[p_blk] <= 1'b1;
                line[p_blk] <= put_word(rin_data, p_word, p_wdata);
                cpu_rdata <= p_wdata;
              end
            endcase
          end
        end else begin
          case (rin_kind)
            K_RD: if (vld[rin_blk] && !rin_served) begin
              rout_data <= line[rin_blk]; rout_served <= 1'b1; exc[rin_blk] <= 1'b0;
            end
            K_INV: begin
              vld[rin_blk] <= 1'b0; exc[rin_blk] <= 1'b0;
            end
            K_RDINV: if (vld[rin_blk]) begin
              if (!rin_served) begin
                rout_data <= line[rin_blk]; rout_served <= 1'b1;
              end
              vld[rin_blk] <= 1'b0; exc[rin_blk] <= 1'b0;
            end
            K_WB: if (HOME[rin_blk] && !rin_served) begin
              line[rin_blk] <= rin_data; vld[rin_blk] <= 1'b1; rout_served <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/ring_block_dir_chk.sv
module ring_block_dir_chk #(
  parameter int NODE_ID = 0,
  parameter int NBLK    = 8,
  parameter int NODE_W  = 2,
  parameter int BLK_W   = 3,
  parameter int LINE_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              rin_valid,
  input logic              rin_ready,
  input logic [2:0]        rin_kind,
  input logic [NODE_W-1:0] rin_src,
  input logic [BLK_W-1:0]  rin_blk,
  input logic              rin_served,
  input logic [LINE_W-1:0] rin_data,
  input logic              rout_valid,
  input logic [2:0]        rout_kind,
  input logic [NODE_W-1:0] rout_src,
  input logic [BLK_W-1:0]  rout_blk,
  input logic              rout_served,
  input logic [LINE_W-1:0] rout_data,
  input logic [NBLK-1:0]   vld,
  input logic [NBLK-1:0]   exc,
  input logic [NBLK-1:0]   home_bits
);
  localparam logic [NODE_W-1:0] ME = NODE_W'(NODE_ID);
  wire in_fire = rin_valid && rin_ready;

  a_r2_stall_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> cpu_done);

  a_r1_done_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_stall);

  a_r8_victim_not_home: assert property (@(posedge clk) disable iff (!rst_n)
    (rout_valid && rout_src == ME && rout_kind == 3'd4) |-> !home_bits[rout_blk]);

  a_r7_wb_then_request: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && rin_src == ME && rin_kind == 3'd4) |=>
      (rout_valid && rout_src == ME && (rout_kind == 3'd1 || rout_kind == 3'd3)));

  a_r10_forward_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && rin_kind == 3'd1 && rin_src != ME && !vld[rin_blk]) |=>
      (rout_valid && rout_kind == $past(rin_kind) && rout_blk == $past(rin_blk) &&
       rout_served == $past(rin_served) && rout_data == $past(rin_data)));

  a_r5_excl_has_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (exc & ~vld) == '0);
endmodule

bind ring_block_dir ring_block_dir_chk #(
  .NODE_ID(NODE_ID), .NBLK(NBLK), .NODE_W(NODE_W), .BLK_W(BLK_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
  .rin_valid(rin_valid), .rin_ready(rin_ready), .rin_kind(rin_kind), .rin_src(rin_src),
  .rin_blk(rin_blk), .rin_served(rin_served), .rin_data(rin_data),
  .rout_valid(rout_valid), .rout_kind(rout_kind), .rout_src(rout_src), .rout_blk(rout_blk),
  .rout_served(rout_served), .rout_data(rout_data),
  .vld(vld), .exc(exc), .home_bits(HOME)
);

// File: tb/ring_block_dir_tb.sv
module ring_block_dir_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        creq [3];
  logic        cwe  [3];
  logic [5:0]  caddr[3];
  logic [31:0] cwd  [3];
  logic        stall[3];
  logic        done [3];
  logic [31:0] crd  [3];

  logic         o_v [3];
  logic [2:0]   o_k [3];
  logic [1:0]   o_s [3];
  logic [2:0]   o_b [3];
  logic         o_sv[3];
  logic [255:0] o_d [3];
  logic         i_rdy[3];

  logic inj = 1'b0;
  logic       n0_v;
  logic [2:0] n0_k;
  assign n0_v = o_v[2] | inj;
  assign n0_k = inj ? 3'd0 : o_k[2];

  ring_block_dir #(.NODES(3), .NODE_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(creq[0]), .cpu_we(cwe[0]), .cpu_addr(caddr[0]),
    .cpu_wdata(cwd[0]), .cpu_stall(stall[0]), .cpu_done(done[0]), .cpu_rdata(crd[0]),
    .rin_valid(n0_v), .rin_ready(i_rdy[0]), .rin_kind(n0_k), .rin_src(o_s[2]),
    .rin_blk(o_b[2]), .rin_served(o_sv[2]), .rin_data(o_d[2]),
    .rout_valid(o_v[0]), .rout_ready(i_rdy[1]), .rout_kind(o_k[0]), .rout_src(o_s[0]),
    .rout_blk(o_b[0]), .rout_served(o_sv[0]), .rout_data(o_d[0]));

  ring_block_dir #(.NODES(3), .NODE_ID(1)) u_n1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(creq[1]), .cpu_we(cwe[1]), .cpu_addr(caddr[1]),
    .cpu_wdata(cwd[1]), .cpu_stall(stall[1]), .cpu_done(done[1]), .cpu_rdata(crd[1]),
    .rin_valid(o_v[0]), .rin_ready(i_rdy[1]), .rin_kind(o_k[0]), .rin_src(o_s[0]),
    .rin_blk(o_b[0]), .rin_served(o_sv[0]), .rin_data(o_d[0]),
    .rout_valid(o_v[1]), .rout_ready(i_rdy[2]), .rout_kind(o_k[1]), .rout_src(o_s[1]),
    .rout_blk(o_b[1]), .rout_served(o_sv[1]), .rout_data(o_d[1]));

  ring_block_dir #(.NODES(3), .NODE_ID(2)) u_n2 (
    .clk(clk), .rst_n(rst_n), .cpu_req(creq[2]), .cpu_we(cwe[2]), .cpu_addr(caddr[2]),
    .cpu_wdata(cwd[2]), .cpu_stall(stall[2]), .cpu_done(done[2]), .cpu_rdata(crd[2]),
    .rin_valid(o_v[1]), .rin_ready(i_rdy[2]), .rin_kind(o_k[1]), .rin_src(o_s[1]),
    .rin_blk(o_b[1]), .rin_served(o_sv[1]), .rin_data(o_d[1]),
    .rout_valid(o_v[2]), .rout_ready(i_rdy[0]), .rout_kind(o_k[2]), .rout_src(o_s[2]),
    .rout_blk(o_b[2]), .rout_served(o_sv[2]), .rout_data(o_d[2]));

  int nchk = 0, nfail = 0;
  logic [31:0] gold [64];

  int sn = 0, wb_tot = 0, wb_bad = 0;
  logic [2:0] sk [4096];
  logic [2:0] sb [4096];
  bit snap1_ok = 0, snap2_ok = 0;
  logic [2:0] s1_k, s2_k, s1_b, s2_b;
  logic s1_sv, s2_sv;
  logic [255:0] s1_d, s2_d;

  always @(posedge clk) begin
    if (o_v[0] && i_rdy[1] && o_k[0] != 3'd0 && o_s[0] == 2'd0 && sn < 4096) begin
      sk[sn] = o_k[0];
      sb[sn] = o_b[0];
      sn++;
      if (o_k[0] == 3'd4) begin
        wb_tot++;
        if (o_b[0] % 3 == 0) wb_bad++;
      end
    end
    if (!snap1_ok && o_v[1] && i_rdy[2] && o_s[1] == 2'd0 && o_k[1] == 3'd1) begin
      snap1_ok = 1; s1_k = o_k[1]; s1_b = o_b[1]; s1_sv = o_sv[1]; s1_d = o_d[1];
    end
    if (!snap2_ok && o_v[2] && i_rdy[0] && o_s[2] == 2'd0 && o_k[2] == 3'd1) begin
      snap2_ok = 1; s2_k = o_k[2]; s2_b = o_b[2]; s2_sv = o_sv[2]; s2_d = o_d[2];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input int n, input bit we, input int a, input logic [31:0] wd,
                    output logic [31:0] rd, output bit miss);
    @(negedge clk);
    while (stall[n]) @(negedge clk);
    creq[n] = 1'b1; cwe[n] = we; caddr[n] = 6'(a); cwd[n] = wd;
    forever begin
      @(negedge clk);
      if (done[n] || stall[n]) break;
    end
    creq[n] = 1'b0;
    miss = stall[n];
    while (!done[n]) @(negedge clk);
    rd = crd[n];
    if (we) gold[a] = wd;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit miss;
    int base, v;
    for (int i = 0; i < 3; i++) begin
      creq[i] = 0; cwe[i] = 0; caddr[i] = 0; cwd[i] = 0;
    end
    for (int i = 0; i < 64; i++) gold[i] = 32'h0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall[0] && !stall[1] && !stall[2] && !done[0], "R9 reset no stall", {31'd0, stall[0]}, 0);
    inj = 1'b1;
    @(negedge clk);
    inj = 1'b0;

    op(0, 0, 0*8+3, 0, rd, miss);
    chk(!miss, "R1 home read hit", {31'd0, miss}, 0);
    chk(rd == 32'h0, "R9 reset data zero", rd, 0);

    base = sn;
    op(0, 0, 1*8+0, 0, rd, miss);
    chk(miss, "R2 read miss stalls", {31'd0, miss}, 1);
    chk(sn - base == 1 && sk[base] == 3'd1 && sb[base] == 3'd1, "R2 read request kind", {29'd0, sk[base]}, 1);
    chk(rd == gold[8], "R3 miss data", rd, gold[8]);
    chk(snap1_ok && snap2_ok && s1_k == s2_k && s1_b == s2_b && s1_sv == s2_sv && s1_d == s2_d && s2_sv,
        "R10 forward unchanged", {31'd0, s2_sv}, 1);

    op(1, 0, 1*8+0, 0, rd, miss);
    chk(!miss, "R3 server keeps copy", {31'd0, miss}, 0);

    base = sn;
    op(0, 1, 1*8+2, 32'hCAFE0001, rd, miss);
    chk(miss && sk[base] == 3'd2, "R5 invalidate packet", {29'd0, sk[base]}, 2);
    op(1, 0, 1*8+2, 0, rd, miss);
    chk(miss, "R5 other copy dropped", {31'd0, miss}, 1);
    chk(rd == 32'hCAFE0001, "R5 new value seen", rd, 32'hCAFE0001);

    base = sn;
    op(0, 1, 2*8+1, 32'hBEEF0002, rd, miss);
    chk(miss && sk[base] == 3'd3, "R6 read-invalidate packet", {29'd0, sk[base]}, 3);
    op(2, 0, 2*8+1, 0, rd, miss);
    chk(miss, "R6 holder copy dropped", {31'd0, miss}, 1);
    chk(rd == 32'hBEEF0002, "R6 merged value", rd, 32'hBEEF0002);
    op(2, 0, 2*8+0, 0, rd, miss);
    chk(rd == gold[16], "R6 rest of block kept", rd, gold[16]);

    base = sn;
    op(0, 1, 0*8+0, 32'h1234ABCD, rd, miss);
    chk(!miss && sn == base, "R4 exclusive write local", sn - base, 0);
    op(0, 0, 0*8+0, 0, rd, miss);
    chk(!miss && rd == 32'h1234ABCD, "R4 readback", rd, 32'h1234ABCD);

    base = sn;
    op(0, 0, 4*8+5, 0, rd, miss);
    chk(sn - base == 2 && sk[base] == 3'd4 && sk[base+1] == 3'd1, "R7 writeback before request",
        {29'd0, sk[base]}, 4);
    chk(rd == gold[37], "R7 miss data", rd, gold[37]);
    v = int'(sb[base]);
    chk(v == 1 || v == 2, "R8 victim not home", v, 1);
    op(0, 0, v*8 + ((v == 1) ? 2 : 1), 0, rd, miss);
    chk(miss, "R7 victim misses", {31'd0, miss}, 1);
    chk(rd == gold[v*8 + ((v == 1) ? 2 : 1)], "R7 victim value", rd, gold[v*8 + ((v == 1) ? 2 : 1)]);

    for (int i = 0; i < 400; i++) begin
      int n, a;
      bit we;
      logic [31:0] wd, exp;
      n = int'($urandom % 3);
      we = 1'($urandom % 2);
      a = int'($urandom % 64);
      wd = $urandom;
      exp = gold[a];
      op(n, we, a, wd, rd, miss);
      if (!we) chk(rd == exp, "R3 random coherence", rd, exp);
    end
    op(0, 0, 0, 0, rd, miss);
    chk(rd == gold[0], "R3 final read", rd, gold[0]);
    chk(wb_tot > 0 && wb_bad == 0, "R8 no home victim", wb_bad, 0);

    report();
    $finish;
  end
endmodule